// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block sequences data movement between a fast volatile array and the nonvolatile shadow copy behind it. It decides when a store (volatile to nonvolatile) or a recall (nonvolatile to volatile) runs and gates host reads and writes around those operations. It drives enable strobes to an abstract array model: one for store, one for the clear step of a recall and one for the transfer step of a recall. Cycle counts stand in for the grace, store, clear and transfer times.

Three things can start a store. A power-loss comparator starts one, as does an active-low hardware request line, which may be shared by several devices. A one-cycle software pulse also starts one. The power-loss and hardware requests are skipped when no write has landed since the last store or recall. A hardware request opens a grace window in which reads continue but new writes are held off. A recall runs at power-up (reset release) and on a software pulse. While a store runs, the block pulls the shared busy line low through an open-drain-style enable.

Top module: `nv_xfer_seq`

## Requirements
- R1: While reset is asserted and for CLR_CYC cycles after its release, `clr_en` is high. Then `xfer_en` is high for XFER_CYC cycles. `host_busy` is high throughout, and `dirty` is 0 after reset.
- R2: A granted write (`wr_grant`=1) sets `dirty` in the next cycle. `dirty` returns to 0 when a store or a recall completes.
- R3: When `pwr_low` is seen, `cap_disc` goes to 1 and stays there until reset. If `dirty` is 1, a store of STORE_CYC cycles begins one cycle later. If `dirty` is 0, no store runs.
- R4: `hw_req_n`=0 with `dirty`=1 opens a grace window of DLY_CYC cycles, followed by a store of STORE_CYC cycles. Reads are granted during the grace window. With `dirty`=0 the request runs no store.
- R5: While `hw_req_n` is 0, no write is granted, whatever the value of `dirty`.
- R6: A `sw_store` pulse in the idle state starts a store of STORE_CYC cycles one cycle later, whether or not `dirty` is set.
- R7: `busy_pull` (1 = pull the shared busy line low) is high in exactly the cycles in which `st_en` is high.
- R8: While a store, clear or transfer runs, `host_busy` is 1 and no read or write is granted. A write attempted then leaves `dirty` at 0.
- R9: A `sw_recall` pulse in the idle state runs CLR_CYC cycles of `clr_en`, then XFER_CYC cycles of `xfer_en`, and leaves `dirty` at 0. Recalls can be repeated back to back.
- R10: A store and a recall never overlap. A store request made during a recall waits and starts one cycle after the recall ends. If store and recall are requested in the same cycle, the store runs first and the recall starts one cycle after the store ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| pwr_low | input | 1 | Backup capacitor below switch threshold |
| hw_req_n | input | 1 | Active-low hardware store request line |
| sw_store | input | 1 | Software store pulse |
| sw_recall | input | 1 | Software recall pulse |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write request |
| rd_grant | output | 1 | Read accepted this cycle |
| wr_grant | output | 1 | Write accepted this cycle |
| host_busy | output | 1 | Block busy, host access rejected |
| busy_pull | output | 1 | Pull shared busy line low |
| cap_disc | output | 1 | Capacitor disconnected from supply |
| st_en | output | 1 | Store strobe to array |
| clr_en | output | 1 | Recall clear strobe to array |
| xfer_en | output | 1 | Recall transfer strobe to array |
| dirty | output | 1 | Write since last store or recall |

## Verification
If the write-since-transfer flag is wrong, it shows at once as a missing store or an extra one after a power-loss or hardware request. The bench sweeps every trigger against both flag values and measures each strobe's run length to the cycle. A phase counter or state that is wrong shows as a grace, store, clear or transfer window off by a cycle or more. Bad gating shows as a grant during a busy cycle, or as a pending request that is lost or runs early, visible within one cycle of the recall ending.

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq #(
  parameter int DLY_CYC   = 4,
  parameter int STORE_CYC = 6,
  parameter int CLR_CYC   = 3,
  parameter int XFER_CYC  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_low,
  input  logic hw_req_n,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic host_rd,
  input  logic host_wr,
  output logic rd_grant,
  output logic wr_grant,
  output logic host_busy,
  output logic busy_pull,
  output logic cap_disc,
  output logic st_en,
  output logic clr_en,
  output logic xfer_en,
  output logic dirty
);
  localparam int M1 = (DLY_CYC > STORE_CYC) ? DLY_CYC : STORE_CYC;
  localparam int M2 = (CLR_CYC > XFER_CYC) ? CLR_CYC : XFER_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_GRACE, S_STORE, S_CLR, S_XFER} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic pend_st, pend_rc;
  logic last;

  assign last      = (cnt == '0);
  assign st_en     = (st == S_STORE);
  assign clr_en    = (st == S_CLR);
  assign xfer_en   = (st == S_XFER);
  assign busy_pull = st_en;
  assign host_busy = st_en | clr_en | xfer_en;
  assign rd_grant  = host_rd & ~host_busy;
  assign wr_grant  = host_wr & ~host_busy & hw_req_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_CLR;
      cnt      <= CW'(CLR_CYC - 1);
      dirty    <= 1'b0;
      pend_st  <= 1'b0;
      pend_rc  <= 1'b0;
      cap_disc <= 1'b0;
    end else begin
      if (pwr_low) cap_disc <= 1'b1;
      if (wr_grant) dirty <= 1'b1;
      if (sw_store) pend_st <= 1'b1;
      if (sw_recall) pend_rc <= 1'b1;
      case (st)
        S_IDLE: begin
          if ((pwr_low && dirty) || sw_store || pend_st) begin
            st      <= S_STORE;
            cnt     <= CW'(STORE_CYC - 1);
            pend_st <= 1'b0;
          end else if (!hw_req_n && dirty) begin
            st  <= S_GRACE;
            cnt <= CW'(DLY_CYC - 1);
          end else if (sw_recall || pend_rc) begin
            st      <= S_CLR;
            cnt     <= CW'(CLR_CYC - 1);
            pend_rc <= 1'b0;
          end
        end
        S_GRACE: begin
          if (last) begin
            st      <= S_STORE;
            cnt     <= CW'(STORE_CYC - 1);
            pend_st <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        S_STORE: begin
          if (last) begin
            st    <= S_IDLE;
            dirty <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        S_CLR: begin
          if (last) begin
            st  <= S_XFER;
            cnt <= CW'(XFER_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_XFER: begin
          if (last) begin
            st    <= S_IDLE;
            dirty <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |=> dirty);
  a_r2_dirty_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_en) || $fell(xfer_en)) |-> !dirty);
  a_r9_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_en) |-> $past(clr_en));
  a_r10_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_en, clr_en, xfer_en}));
  a_r5_wr_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_req_n |-> !wr_grant);
  a_r3_store_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_en) |-> ($past(dirty) || $past(sw_store) || $past(pend_st)));
  a_r3_disc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cap_disc |=> cap_disc);
endmodule

// File: tb/nv_xfer_seq_tb.sv
`timescale 1ns/1ps
module nv_xfer_seq_tb;
  localparam int DLY = 4, STC = 6, CLC = 3, XFC = 5;
  logic clk = 0, rst_n = 0;
  logic pwr_low = 0, hw_req_n = 1, sw_store = 0, sw_recall = 0, host_rd = 0, host_wr = 0;
  logic rd_grant, wr_grant, host_busy, busy_pull, cap_disc, st_en, clr_en, xfer_en, dirty;
  int tests = 0, fails = 0, bad = 0;

  always #2.5 clk = ~clk;

  nv_xfer_seq #(.DLY_CYC(DLY), .STORE_CYC(STC), .CLR_CYC(CLC), .XFER_CYC(XFC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_low(pwr_low), .hw_req_n(hw_req_n), .sw_store(sw_store),
    .sw_recall(sw_recall), .host_rd(host_rd), .host_wr(host_wr), .rd_grant(rd_grant),
    .wr_grant(wr_grant), .host_busy(host_busy), .busy_pull(busy_pull), .cap_disc(cap_disc),
    .st_en(st_en), .clr_en(clr_en), .xfer_en(xfer_en), .dirty(dirty));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    return (sel == 0) ? st_en : (sel == 1) ? clr_en : xfer_en;
  endfunction

  task automatic meas(input int sel, input int lim, output int pre, output int len);
    pre = 0; len = 0;
    while (!sig(sel) && pre < lim) begin @(negedge clk); pre++; end
    while (sig(sel) && len < 100) begin
      if (!host_busy || rd_grant || wr_grant) bad++;
      if ((st_en == 1'b1) != (busy_pull == 1'b1)) bad++;
      if (int'(st_en) + int'(clr_en) + int'(xfer_en) > 1) bad++;
      @(negedge clk); len++;
    end
  endtask

  task automatic do_write();
    host_wr = 1;
    #0.1;
    chk("R2 write granted", int'(wr_grant), 1);
    @(negedge clk); host_wr = 0;
    chk("R2 dirty set", int'(dirty), 1);
  endtask

  initial begin
    #(200000 * 5);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int pre, len;
    repeat (3) @(negedge clk);
    chk("R1 reset clr_en", int'(clr_en), 1);
    chk("R1 reset busy", int'(host_busy), 1);
    chk("R1 reset dirty", int'(dirty), 0);
    chk("R3 reset cap_disc", int'(cap_disc), 0);
    chk("R7 reset busy_pull", int'(busy_pull), 0);
    rst_n = 1;
    meas(1, 0, pre, len); chk("R1 clear len", len, CLC);
    meas(2, 0, pre, len); chk("R1 xfer len", len, XFC);
    chk("R1 idle after", int'(host_busy), 0);

    for (int trig = 0; trig < 3; trig++) begin
      for (int d = 0; d < 2; d++) begin
        bad = 0;
        if (d == 1) do_write();
        if (trig == 0) begin
          pwr_low = 1; @(negedge clk);
          chk("R3 cap_disc set", int'(cap_disc), 1);
          meas(0, 20, pre, len);
          chk("R3 auto store len", len, d ? STC : 0);
          if (d) chk("R3 auto start", pre, 0);
          pwr_low = 0;
        end else if (trig == 1) begin
          hw_req_n = 0; host_rd = 1; host_wr = 1; @(negedge clk);
          chk("R4 read in window", int'(rd_grant), 1);
          chk("R5 write inhibited", int'(wr_grant), 0);
          host_rd = 0; host_wr = 0;
          meas(0, 20, pre, len);
          chk("R4 hw store len", len, d ? STC : 0);
          if (d) chk("R4 grace len", pre, DLY);
          hw_req_n = 1; @(negedge clk);
        end else begin
          sw_store = 1; @(negedge clk); sw_store = 0;
          host_rd = 1; host_wr = 1;
          meas(0, 0, pre, len);
          host_rd = 0; host_wr = 0;
          chk("R6 sw store len", len, STC);
        end
        @(negedge clk);
        chk("R2 dirty after", int'(dirty), 0);
        chk("R7 R8 busy and gating", bad, 0);
      end
    end
    chk("R3 cap_disc sticky", int'(cap_disc), 1);

    for (int k = 0; k < 2; k++) begin
      bad = 0;
      do_write();
      sw_recall = 1; @(negedge clk); sw_recall = 0;
      host_rd = 1;
      meas(1, 0, pre, len); chk("R9 clear len", len, CLC);
      meas(2, 0, pre, len); chk("R9 xfer len", len, XFC);
      host_rd = 0;
      chk("R9 dirty cleared", int'(dirty), 0);
      chk("R8 no grant in recall", bad, 0);
    end

    bad = 0;
    sw_recall = 1; @(negedge clk); sw_recall = 0;
    sw_store = 1; @(negedge clk); sw_store = 0;
    meas(1, 0, pre, len); chk("R10 clear rest", len, CLC - 1);
    meas(2, 0, pre, len); chk("R10 xfer len", len, XFC);
    meas(0, 10, pre, len);
    chk("R10 waited store gap", pre, 1);
    chk("R10 waited store len", len, STC);

    sw_store = 1; sw_recall = 1; @(negedge clk); sw_store = 0; sw_recall = 0;
    meas(0, 0, pre, len); chk("R10 store first len", len, STC);
    meas(1, 10, pre, len);
    chk("R10 recall gap", pre, 1);
    chk("R10 recall after store", len, CLC);
    meas(2, 0, pre, len); chk("R10 xfer after", len, XFC);
    chk("R10 no overlap", bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule